// File: doc/BRIEF.md
# Spike Decoding Thinning Accumulator Bank

This block converts a stream of neuron spike events into sparse trains of signed unit pulses. Each pulse rate equals a weighted sum of the input spike rates. An incoming event names one neuron. The block walks that neuron's row of entries in an internal weight store. Each entry pairs a signed fixed-point decode weight with the index of the bucket it feeds. The weight is added to the running state of that bucket. When a bucket's state reaches plus one, the bucket emits a positive unit pulse and gives back one unit. When it reaches minus one, it emits a negative pulse and takes one unit back.

The thinning is fully deterministic. For weights below one in magnitude, the output carries fewer pulses than the input carried spikes, and those pulses come out evenly spaced. Each output pulse has only a sign and a bucket index, so the consumer downstream never has to convert a multibit magnitude. Software fills the weight store through a simple write port before spikes are sent. Spikes enter and pulses leave through valid/ready handshakes.

Top module: `spk_thin_accum`

## Requirements
- R1: Synchronous active-high reset clears every bucket state to zero, drops `out_valid` and raises `in_ready`. A row that would push a bucket past a threshold only from state it held before the reset then emits nothing.
- R2: A weight is an 8-bit two's complement value that stands for value/128. So 0x80 is -1.0, 0x40 is +0.5 and 0x7F is +127/128.
- R3: A spike accepted for neuron n adds each of the 16 entries at store addresses n*16 .. n*16+15 to the bucket named by that entry's index field, one entry per clock.
- R4: When a bucket's state plus the added weight is at least +1.0, the block emits a pulse with `out_neg`=0 and that bucket's index on `out_bucket`, and the bucket keeps the sum minus 1.0.
- R5: When the sum is at most -1.0, the block emits a pulse with `out_neg`=1 and adds 1.0 to the sum. A negative pulse only ever follows a negative weight.
- R6: While `out_valid` is high and `out_ready` is low, the output pulse and its fields hold steady and row processing pauses. No pulse is lost.
- R7: `in_ready` falls for exactly 16 cycles after a spike is accepted when the output is not blocked.
- R8: A zero weight changes no bucket state and emits no pulse.
- R9: Over any run starting from reset, each bucket's net pulse count (positive minus negative) times 1.0 differs from the sum of weights applied to it by less than 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Weight store write strobe |
| cfg_addr | input | 10 | Store address, neuron*16 + slot |
| cfg_weight | input | 8 | Signed weight, value/128 |
| cfg_bucket | input | 4 | Target bucket index for the entry |
| in_valid | input | 1 | Spike event valid |
| in_ready | output | 1 | Block can accept a spike |
| in_neuron | input | 6 | Neuron address of the spike |
| out_valid | output | 1 | Unit pulse valid |
| out_ready | input | 1 | Consumer accepts the pulse |
| out_bucket | output | 4 | Bucket that emitted the pulse |
| out_neg | output | 1 | Pulse sign, 1 for negative |

## Verification
The hardest situation to reach from the ports is a row stalled in the middle by output backpressure. In that case a registered store read, a pending bucket update and a held pulse all have to survive together. The stimulus keeps `out_ready` low while a row of -1.0 weights runs, which freezes the pipeline with a pulse waiting. It later drives `out_ready` from a pseudo-random bit stream while hundreds of spikes hit randomly configured rows. The per-bucket net pulse counts are then compared with the weight sums the bench accumulates on its own.

// File: rtl/spk_thin_pkg.sv
package spk_thin_pkg;
  typedef enum logic {
    PULSE_POS = 1'b0,
    PULSE_NEG = 1'b1
  } pulse_sign_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/spk_wmem.sv
module spk_wmem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spk_row_seq.sv
module spk_row_seq #(
  parameter int N_NEURONS = 64,
  parameter int ROW_LEN   = 16,
  localparam int NID_W    = $clog2(N_NEURONS),
  localparam int SLOT_W   = $clog2(ROW_LEN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    advance,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NID_W-1:0]        in_neuron,
  output logic                    rd_en,
  output logic [NID_W+SLOT_W-1:0] rd_addr,
  output logic                    ent_v
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(ROW_LEN - 1);

  logic              busy_q;
  logic [NID_W-1:0]  nid_q;
  logic [SLOT_W-1:0] slot_q;

  assign in_ready = !busy_q;
  assign rd_en    = advance && busy_q;
  assign rd_addr  = {nid_q, slot_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      nid_q  <= '0;
      slot_q <= '0;
      ent_v  <= 1'b0;
    end else begin
      if (advance) ent_v <= busy_q;
      if (busy_q && advance) begin
        slot_q <= slot_q + 1'b1;
        if (slot_q == LAST) busy_q <= 1'b0;
      end else if (!busy_q && in_valid) begin
        busy_q <= 1'b1;
        nid_q  <= in_neuron;
        slot_q <= '0;
      end
    end
  end
endmodule

// File: rtl/spk_bucket_bank.sv
module spk_bucket_bank #(
  parameter int N_BUCKETS = 16,
  parameter int W_W       = 8,
  localparam int ACC_W    = W_W + 2,
  localparam int BIDX_W   = $clog2(N_BUCKETS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic [BIDX_W-1:0]        upd_idx,
  input  logic signed [W_W-1:0]    upd_w,
  output logic                     emit,
  output logic                     emit_neg
);
  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1 << (W_W - 1));
  localparam logic signed [ACC_W-1:0] NEG_ONE = -ONE;

  logic signed [ACC_W-1:0] st_q [N_BUCKETS];
  logic signed [ACC_W-1:0] cur, sum, nxt;

  always_comb begin
    cur      = st_q[upd_idx];
    sum      = cur + ACC_W'(upd_w);
    emit     = 1'b0;
    emit_neg = 1'b0;
    nxt      = sum;
    if (sum >= ONE) begin
      emit = 1'b1;
      nxt  = sum - ONE;
    end else if (sum <= NEG_ONE) begin
      emit     = 1'b1;
      emit_neg = 1'b1;
      nxt      = sum + ONE;
    end
  end

  for (genvar i = 0; i < N_BUCKETS; i++) begin : g_bucket
    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= '0;
      else if (upd && (upd_idx == BIDX_W'(i))) st_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/spk_thin_accum.sv
module spk_thin_accum #(
  parameter int N_NEURONS = 64,
  parameter int ROW_LEN   = 16,
  parameter int N_BUCKETS = 16,
  parameter int W_W       = 8,
  localparam int NID_W    = $clog2(N_NEURONS),
  localparam int SLOT_W   = $clog2(ROW_LEN),
  localparam int AW       = NID_W + SLOT_W,
  localparam int BIDX_W   = $clog2(N_BUCKETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [W_W-1:0]    cfg_weight,
  input  logic [BIDX_W-1:0] cfg_bucket,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NID_W-1:0]  in_neuron,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BIDX_W-1:0] out_bucket,
  output logic              out_neg
);
  import spk_thin_pkg::*;

  localparam int DEPTH = N_NEURONS * ROW_LEN;
  localparam int DW    = W_W + BIDX_W;

  logic              advance, rd_en, ent_v, upd_fire, emit, emit_neg;
  logic [AW-1:0]     rd_addr;
  logic [DW-1:0]     ent_q;
  logic [W_W-1:0]    ent_w;
  logic [BIDX_W-1:0] ent_b;

  assign advance  = !out_valid || out_ready;
  assign upd_fire = ent_v && advance;
  assign ent_w    = ent_q[DW-1:BIDX_W];
  assign ent_b    = ent_q[BIDX_W-1:0];

  spk_row_seq #(.N_NEURONS(N_NEURONS), .ROW_LEN(ROW_LEN)) u_seq (
    .clk(clk), .rst(rst), .advance(advance),
    .in_valid(in_valid), .in_ready(in_ready), .in_neuron(in_neuron),
    .rd_en(rd_en), .rd_addr(rd_addr), .ent_v(ent_v)
  );

  spk_wmem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wdata({cfg_weight, cfg_bucket}),
    .re(rd_en), .raddr(rd_addr), .rdata(ent_q)
  );

  spk_bucket_bank #(.N_BUCKETS(N_BUCKETS), .W_W(W_W)) u_bank (
    .clk(clk), .rst(rst), .upd(upd_fire), .upd_idx(ent_b),
    .upd_w(ent_w), .emit(emit), .emit_neg(emit_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_bucket <= '0;
      out_neg    <= PULSE_POS;
    end else if (advance) begin
      out_valid  <= upd_fire && emit;
      out_bucket <= ent_b;
      out_neg    <= emit_neg ? PULSE_NEG : PULSE_POS;
    end
  end
endmodule

// File: rtl/spk_thin_accum_chk.sv
module spk_thin_accum_chk #(
  parameter int W_W    = 8,
  parameter int BIDX_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BIDX_W-1:0] out_bucket,
  input logic              out_neg,
  input logic              upd_fire,
  input logic [W_W-1:0]    upd_w
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bucket) && $stable(out_neg)));

  assert_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_pulse_src_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(upd_fire));

  assert_neg_sign_R5: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> (!out_valid || (out_neg == $past(upd_w[W_W-1]))));

  assert_zero_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && (upd_w == '0)) |=> !out_valid);
endmodule

bind spk_thin_accum spk_thin_accum_chk #(.W_W(W_W), .BIDX_W(BIDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bucket(out_bucket),
  .out_neg(out_neg), .upd_fire(upd_fire), .upd_w(ent_w)
);

// File: tb/sim_spk_thin_accum.sv
`timescale 1ns/1ps
module sim_spk_thin_accum;
  localparam int NN = 64, RL = 16, NB = 16, CLKP = 4;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [9:0] cfg_addr = 0;
  logic [7:0] cfg_weight = 0;
  logic [3:0] cfg_bucket = 0;
  logic in_valid = 0;
  logic [5:0] in_neuron = 0;
  logic ready_man = 1, bp_en = 0, rnd_bit = 1;
  wire  out_ready = bp_en ? rnd_bit : ready_man;
  wire  in_ready, out_valid, out_neg;
  wire [3:0] out_bucket;

  always #(CLKP/2) clk = ~clk;

  spk_thin_accum u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_weight(cfg_weight), .cfg_bucket(cfg_bucket), .in_valid(in_valid),
    .in_ready(in_ready), .in_neuron(in_neuron), .out_valid(out_valid),
    .out_ready(out_ready), .out_bucket(out_bucket), .out_neg(out_neg)
  );

  int total = 0, bad = 0;
  int pos_cnt [NB];
  int neg_cnt [NB];
  int cw [NN][RL];
  int cb [NN][RL];
  logic [15:0] lfsr = 16'hACE1;

  initial for (int i = 0; i < NB; i++) begin pos_cnt[i] = 0; neg_cnt[i] = 0; end

  always @(negedge clk)
    if (!rst && out_valid && out_ready) begin
      if (out_neg) neg_cnt[out_bucket]++;
      else         pos_cnt[out_bucket]++;
    end

  always @(posedge clk) begin
    #1 lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rnd_bit = lfsr[3] | lfsr[7];
  end

  // neuron, expected positive pulses, expected negative pulses, sole bucket (-1 = many)
  localparam int VN = 6;
  localparam int VEC [VN][4] = '{
    '{0, 8, 0, 3},   // 16 x +0.5 into bucket 3
    '{1, 0, 16, 5},  // 16 x -1.0 into bucket 5
    '{2, 0, 0, -1},  // zero weights
    '{3, 0, 0, -1},  // +127/128 each bucket, first pass
    '{3, 16, 0, -1}, // second pass crosses
    '{4, 1, 0, 7}    // +100/-100 alternating on bucket 7 (state 126 before)
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic cfg(input int n, input int s, input int w, input int b);
    cw[n][s] = w; cb[n][s] = b;
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 10'(n * RL + s); cfg_weight = 8'(w); cfg_bucket = 4'(b);
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic send(input int n);
    bit acc;
    @(posedge clk); #1;
    in_neuron = 6'(n); in_valid = 1;
    forever begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    in_valid = 0;
  endtask

  function automatic int sum_pos();
    int s = 0;
    for (int i = 0; i < NB; i++) s += pos_cnt[i];
    return s;
  endfunction

  function automatic int sum_neg();
    int s = 0;
    for (int i = 0; i < NB; i++) s += neg_cnt[i];
    return s;
  endfunction

  initial begin
    #(CLKP * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, n0, b0, lowc;
    int snap_p [NB];
    int snap_n [NB];
    int wsum [NB];
    do_reset();
    @(negedge clk);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);

    for (int n = 0; n < NN; n++)
      for (int s = 0; s < RL; s++) begin
        int w, b;
        w = 0; b = s;
        case (n)
          0: begin w = 64; b = 3; end
          1: begin w = -128; b = 5; end
          3: w = 127;
          4: begin w = (s % 2 == 0) ? 100 : -100; b = 7; end
          default: ;
        endcase
        cfg(n, s, w, b);
      end

    // R2 R3 R4 R5 R8: table walk from zero state
    for (int v = 0; v < VN; v++) begin
      p0 = sum_pos(); n0 = sum_neg();
      b0 = (VEC[v][3] >= 0) ? pos_cnt[VEC[v][3]] + neg_cnt[VEC[v][3]] : 0;
      send(VEC[v][0]);
      repeat (30) @(posedge clk);
      @(negedge clk);
      check(sum_pos() - p0 == VEC[v][1], "R2/R4 table positive pulses", sum_pos() - p0, VEC[v][1]);
      check(sum_neg() - n0 == VEC[v][2], "R2/R5 table negative pulses", sum_neg() - n0, VEC[v][2]);
      if (VEC[v][3] >= 0)
        check(pos_cnt[VEC[v][3]] + neg_cnt[VEC[v][3]] - b0 == VEC[v][1] + VEC[v][2],
              "R3 pulses on addressed bucket",
              pos_cnt[VEC[v][3]] + neg_cnt[VEC[v][3]] - b0, VEC[v][1] + VEC[v][2]);
    end

    // R7 busy window and R8 zero row
    do_reset();
    p0 = sum_pos(); n0 = sum_neg();
    send(2);
    lowc = 0;
    repeat (24) begin @(negedge clk); if (!in_ready) lowc++; end
    check(lowc == 16, "R7 in_ready low cycles", lowc, 16);
    check(sum_pos() + sum_neg() == p0 + n0, "R8 zero row pulses", sum_pos() + sum_neg() - p0 - n0, 0);

    // R6 backpressure mid-row
    do_reset();
    ready_man = 0;
    n0 = neg_cnt[5];
    send(1);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1, "R6 pulse held", out_valid, 1);
    check(out_bucket == 4'd5, "R6 held bucket", out_bucket, 5);
    check(out_neg == 1, "R6 held sign", out_neg, 1);
    check(in_ready == 0, "R6 row paused", in_ready, 0);
    @(posedge clk); #1 ready_man = 1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(neg_cnt[5] - n0 == 16, "R6 no pulse lost", neg_cnt[5] - n0, 16);

    // R1 reset clears accumulated state
    do_reset();
    send(3);
    repeat (30) @(posedge clk);
    do_reset();
    p0 = sum_pos();
    send(3);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(sum_pos() == p0, "R1 state cleared by reset", sum_pos() - p0, 0);

    // R9 long run with random rows and random backpressure
    for (int n = 8; n < 16; n++)
      for (int s = 0; s < RL; s++)
        cfg(n, s, int'($signed(lfsr[11:4])), int'(lfsr[15:12] ^ 4'(s)));
    do_reset();
    for (int i = 0; i < NB; i++) begin
      snap_p[i] = pos_cnt[i]; snap_n[i] = neg_cnt[i]; wsum[i] = 0;
    end
    bp_en = 1;
    for (int k = 0; k < 300; k++) begin
      int n;
      n = 8 + int'(lfsr[2:0]);
      for (int s = 0; s < RL; s++) wsum[cb[n][s]] += cw[n][s];
      send(n);
    end
    @(posedge clk); #1 bp_en = 0; ready_man = 1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      int net, diff;
      net  = (pos_cnt[i] - snap_p[i]) - (neg_cnt[i] - snap_n[i]);
      diff = wsum[i] - net * 128;
      check(diff > -128 && diff < 128, "R9 net pulses track weight sum", net * 128, wsum[i]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule